// File: doc/BRIEF.md
# Combined INTx and MSI Interrupt Status Unit

This unit gathers the four legacy level-sensitive interrupt lines of a PCI Express root port (INTA to INTD) and a single MSI-pending indication. It captures them into one sticky status word and drives a single interrupt request toward the host. A second word holds per-source enable bits. The request is raised whenever any captured source is also enabled.

Software reads the status word through a simple register bus. It writes ones to retire the sources it has handled, and it keeps polling until the INTx field reads zero. A line that is still asserted while its bit is being cleared sets the bit again at once. Each source can be masked or unmasked on its own through the enable word. MSI decoding and routing to a processor take place outside this unit.

Top module: `irq_merge_unit`

## Requirements
- R1: After reset the status word, the enable word and `irq_out` are all zero.
- R2: INTx line n (n = 0..3) sampled high at a clock edge sets status bit 5+n at that edge. The bit stays set after the line falls.
- R3: A write to the status word (offset 0) clears every INTx or MSI status bit written with 1 and leaves bits written with 0 unchanged.
- R4: When a line is high in the same cycle that its status bit is written with 1, the bit stays set (set wins over clear).
- R5: `msi_pend` sampled high sets status bit 3. The bit is sticky and is cleared by writing 1 to it.
- R6: The enable word (offset 4) holds bits 3 (MSI) and 5..8 (INTx A..D), each written independently. It keeps its value when it is not written, and its other bits read 0.
- R7: `irq_out` is high exactly one cycle after a clock edge at which the status word ANDed with the enable word was nonzero.
- R8: Status bits outside 3 and 5..8 always read 0. A read of any offset other than 0 or 4 returns 0, and a write there changes nothing.
- R9: Writing to the status word never sets a bit. Only a high source sets one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_lvl | input | 4 | Legacy level interrupts A..D |
| msi_pend | input | 1 | MSI pending indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The bench targets a clear that lands while the line is still high. A design that lets the clear win would drop a live level interrupt and leave software believing the field is empty. It writes zeros and stray ones to the status word: a design that treats the write as a plain store would raise spurious status bits or wipe unhandled ones. Per-line masking is exercised with only some enable bits set. A mask applied to the whole field would either silence a pending line or fire `irq_out` for a masked one. The bench also tracks the single-cycle lag of `irq_out` across random traffic, so a combinational or two-stage output would be caught.

// File: rtl/irq_merge_unit.sv
module irq_merge_unit #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int NUM_INTX = 4,
  parameter int INTX_LSB = 5,
  parameter int MSI_BIT  = 3,
  parameter int STAT_OFS = 0,
  parameter int ENAB_OFS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intx_lvl,
  input  logic                msi_pend,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq_out
);
  localparam logic [DW-1:0] ONE        = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] INTX_FIELD = ((ONE << NUM_INTX) - ONE) << INTX_LSB;
  localparam logic [DW-1:0] MSI_FIELD  = ONE << MSI_BIT;
  localparam logic [DW-1:0] FIELD      = INTX_FIELD | MSI_FIELD;

  logic [DW-1:0] st_q, en_q, src_vec, clr_vec;
  logic          irq_q, wr_stat, wr_enab, sel_stat, sel_enab;

  always_comb begin
    src_vec = '0;
    src_vec[INTX_LSB +: NUM_INTX] = intx_lvl;
    src_vec[MSI_BIT] = msi_pend;
  end

  assign sel_stat = (bus_addr == AW'(STAT_OFS));
  assign sel_enab = (bus_addr == AW'(ENAB_OFS));
  assign wr_stat  = bus_wr && sel_stat;
  assign wr_enab  = bus_wr && sel_enab;
  assign clr_vec  = wr_stat ? (bus_wdata & FIELD) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr_vec) | src_vec;
      if (wr_enab) en_q <= bus_wdata & FIELD;
      irq_q <= |(st_q & en_q);
    end
  end

  assign bus_rdata = sel_stat ? st_q : (sel_enab ? en_q : '0);
  assign irq_out   = irq_q;

  // a live source always shows in the status word one edge later, clear or not
  assert_src_captured_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q[INTX_LSB +: NUM_INTX] & $past(intx_lvl)) == $past(intx_lvl)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((st_q & $past(bus_wdata & FIELD & ~src_vec)) == '0));

  assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(src_vec)) == '0));

  assert_enable_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enab |=> $stable(en_q));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | en_q) & ~FIELD) == '0);

  assert_quiet_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & en_q) == '0) |=> !irq_out);
endmodule

// File: tb/tb_irq_merge_unit.sv
module tb_irq_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  intx_lvl;
  logic        msi_pend;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] m_st = '0, m_en = '0;
  logic        m_irq = 1'b0;
  localparam logic [31:0] FIELD = 32'h0000_01E8;

  always #5 clk = ~clk;

  irq_merge_unit dut (
    .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .msi_pend(msi_pend),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'd0) return m_st;
    if (a == 8'd4) return m_en;
    return '0;
  endfunction

  function automatic logic [31:0] src_of(input logic [3:0] ix, input logic m);
    return ({23'd0, ix, 5'd0}) | ({28'd0, m, 3'd0});
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [3:0] ix, input logic m,
                     input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    intx_lvl = ix; msi_pend = m; bus_wr = w; bus_addr = a; bus_wdata = d;
    #2;
    chk(tag, bus_rdata, exp_read(a));
    chk("R7 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    @(posedge clk);
    m_irq = |(m_st & m_en);
    m_st  = (m_st & ~((w && a == 8'd0) ? (d & FIELD) : 32'd0)) | src_of(ix, m);
    if (w && a == 8'd4) m_en = d & FIELD;
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst_n = 1'b0; intx_lvl = '0; msi_pend = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    intx_lvl = 4'hF; msi_pend = 1'b1;
    @(negedge clk);
    bus_addr = 8'd0; #1 chk("R1 status", bus_rdata, 32'd0);
    bus_addr = 8'd4; #1 chk("R1 enable", bus_rdata, 32'd0);
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    intx_lvl = '0; msi_pend = 1'b0;
    rst_n = 1'b1;

    // R2 sticky capture
    cyc("R2 idle", 4'b0010, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R2 set", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R2 sticky", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    chk("R2 bit6", m_st, 32'h40);
    // R3 write zero keeps, write one clears
    cyc("R3 w0", 4'b0000, 1'b0, 1'b1, 8'd0, 32'd0);
    cyc("R3 w1", 4'b0000, 1'b0, 1'b1, 8'd0, 32'h40);
    cyc("R3 cleared", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    // R4 set wins
    cyc("R4 raise", 4'b1000, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R4 clash", 4'b1000, 1'b0, 1'b1, 8'd0, 32'h100);
    cyc("R4 kept", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    chk("R4 bit8", m_st, 32'h100);
    cyc("R4 retire", 4'b0000, 1'b0, 1'b1, 8'd0, 32'h100);
    // R5 MSI pending
    cyc("R5 pend", 4'b0000, 1'b1, 1'b0, 8'd0, 32'd0);
    cyc("R5 sticky", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R5 clear", 4'b0000, 1'b0, 1'b1, 8'd0, 32'h8);
    cyc("R5 gone", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    // R9 writing ones to empty status sets nothing
    cyc("R9 w1s", 4'b0000, 1'b0, 1'b1, 8'd0, 32'hFFFF_FFFF);
    cyc("R9 empty", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    chk("R9 zero", m_st, 32'd0);
    // R6 enable field and per-line mask
    cyc("R6 wr", 4'b0000, 1'b0, 1'b1, 8'd4, 32'hFFFF_FFFF);
    cyc("R6 rd", 4'b0000, 1'b0, 1'b0, 8'd4, 32'd0);
    chk("R6 field", m_en, 32'h1E8);
    cyc("R6 maskB", 4'b0000, 1'b0, 1'b1, 8'd4, 32'h1A8);
    cyc("R6 lineB", 4'b0010, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R7 masked", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R7 masked2", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    chk("R7 masked low", {31'd0, irq_out}, 32'd0);
    cyc("R6 unmaskB", 4'b0000, 1'b0, 1'b1, 8'd4, 32'h40);
    cyc("R7 rise", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    cyc("R7 high", 4'b0000, 1'b0, 1'b0, 8'd0, 32'd0);
    chk("R7 asserted", {31'd0, irq_out}, 32'd1);
    // R8 unused offsets
    cyc("R8 wr", 4'b0000, 1'b0, 1'b1, 8'd8, 32'hFFFF_FFFF);
    cyc("R8 rd", 4'b0000, 1'b0, 1'b0, 8'd8, 32'd0);
    cyc("R8 en", 4'b0000, 1'b0, 1'b0, 8'd4, 32'd0);
    cyc("R8 st", 4'b0000, 1'b0, 1'b1, 8'd0, 32'hFFFF_FFFF);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ix;
      logic [7:0] a;
      logic [31:0] d;
      int pick;
      ix = '0;
      for (int b = 0; b < 4; b++) ix[b] = ($urandom % 8) == 0;
      pick = $urandom % 7;
      a = (pick < 3) ? 8'd0 : (pick < 6) ? 8'd4 : 8'd12;
      d = $urandom;
      cyc((a == 8'd0) ? "R3 rnd status" : (a == 8'd4) ? "R6 rnd enable" : "R8 rnd unused",
          ix, ($urandom % 8) == 0, ($urandom % 4) == 0, a, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule